// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests from a 16-bit processor core into external bus cycles on a 20-bit address space with an 8-bit multiplexed address/data bus. A request names one of seven cycle kinds: interrupt acknowledge, I/O read, I/O write, halt, instruction fetch, memory read and memory write. The sequencer then walks the clock phases T1, T2 and T3, adds wait phases (Tw) as needed, and ends with T4. It drives every bus control output directly from its phase register and the latched request.

The bus has two ready inputs. The synchronous one passes through a two-flop synchronizer. The asynchronous one passes through an extra falling-edge stage before its two flops. The two synchronized levels are ORed, so a board that uses only one of them ties the other low. A separate non-multiplexed address output is updated on the falling clock edge before T1, so it leads the multiplexed bus by half a clock. An external master can take the bus with the hold input. The grant comes only from idle or at the end of T4. While the grant is held, the output enables release the address, data, strobe and status lines.

Top module: `bus_cycle_seq`

## Requirements
- R1: `status` shows the request kind during T1, T2, T3 and every Tw. Kind codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 fetch, 101 memory read and 110 memory write. `status` is 111 in T4, in idle and after reset. A request whose kind is 111 is never accepted.
- R2: `ale` is high for exactly one cycle, T1. In T1, `ad_oe` is high and `ad_out` carries address bits 7:0. `ao_hi` carries address bits 15:8 for the whole cycle. In a write, `ad_out` carries the write data from T2 through T4 with `ad_oe` high.
- R3: For interrupt acknowledge, I/O read, fetch and memory read, `rd_n` is low in T2, T3 and each Tw, and nowhere else. For the two write kinds, `wr_n` is low over the same phases. `wb_n` is low from T1 through T4 of a write cycle.
- R4: The number of Tw phases equals the number of T3/Tw decisions that see neither synchronized ready high. A ready level presented after clock edge n is first used by the decision at edge n+3. This holds for either ready input while the other is held low.
- R5: A halt cycle lasts exactly four cycles, has no wait phase and asserts no read or write strobe.
- R6: `upper_zero` is high from T1 through T4 whenever address bits 19:16 are not all ones. It is low outside a cycle.
- R7: While `hold` is high, `req_ready` is low and no request is accepted. `hlda` rises only after an idle cycle or after T4, never in the middle of a cycle. While `hlda` is high, `bus_oe` and `ad_oe` are low. `hlda` falls one cycle after `hold` is seen low.
- R8: `dt_r` is 1 for writes and 0 for all other kinds, and it changes only when a request is accepted. `den_n` is low in T2, T3, Tw and T4 of every non-halt cycle. `den_n` is high in any cycle in which `dt_r` has just changed.
- R9: `s6` is high in T2, T3, Tw and T4 of a cycle whose request set `req_dma`. Otherwise it is low.
- R10: `addr_out` takes the requested address at the falling edge before T1. It therefore shows the new address while `ad_oe` is still low.
- R11: For reads, the value on `ad_in` at the edge that leaves T3 or Tw is returned on `rd_data`. `rd_valid` is high during T4 of read-kind cycles only.
- R12: After reset the block is idle. `req_ready` and `bus_oe` are high, `hlda` and `ale` are low, and all active-low strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_kind | input | 3 | Cycle kind code (see R1) |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 8 | Write data |
| req_dma | input | 1 | Request comes from a DMA master |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| rdy_async | input | 1 | Ready, asynchronous to the clock |
| rdy_sync | input | 1 | Ready, synchronous to the clock |
| hold | input | 1 | External master wants the bus |
| ad_in | input | 8 | Read data from the multiplexed bus |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_out | output | 20 | Non-multiplexed address, half-cycle early |
| ao_hi | output | 8 | Address bits 15:8 |
| bus_oe | output | 1 | Drive enable for address, strobes and status |
| status | output | 3 | Cycle status code |
| s6 | output | 1 | DMA-cycle indicator |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wb_n | output | 1 | Byte write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| upper_zero | output | 1 | Some bit of address 19:16 is zero |
| hlda | output | 1 | Hold acknowledge |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | rd_data valid (T4 of reads) |

## Verification
The hardest situation to reach from the ports is a hold request that arrives in the middle of a cycle. A grant issued there would float the bus while a strobe is still active. To provoke it, the stimulus raises `hold` during T2 of a read. It then checks that `hlda` is still low in T4 and high in the following cycle.

The wait-state count is the second difficulty. Ready passes through two synchronizers of different latency. The stimulus raises the chosen ready input a programmed number of edges after acceptance and holds the other input low. The expected number of Tw phases is then derived from the edge-plus-three rule and compared with the strobe width.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5,
    PH_HOLD = 3'd6
  } phase_e;

  localparam logic [2:0] K_INTA   = 3'b000;
  localparam logic [2:0] K_IORD   = 3'b001;
  localparam logic [2:0] K_IOWR   = 3'b010;
  localparam logic [2:0] K_HALT   = 3'b011;
  localparam logic [2:0] K_FETCH  = 3'b100;
  localparam logic [2:0] K_MEMRD  = 3'b101;
  localparam logic [2:0] K_MEMWR  = 3'b110;
  localparam logic [2:0] K_IDLE   = 3'b111;

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == K_IOWR) || (k == K_MEMWR);
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == K_INTA) || (k == K_IORD) || (k == K_FETCH) || (k == K_MEMRD);
  endfunction

  function automatic logic kind_waits(input logic [2:0] k);
    return k != K_HALT;
  endfunction

  function automatic logic nibble_has_zero(input logic [3:0] n);
    return ~n[3] | ~n[2] | ~n[1] | ~n[0];
  endfunction

  function automatic logic phase_in_cycle(input phase_e p);
    return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
  endfunction

  function automatic logic phase_strobe(input phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction

  function automatic logic phase_data(input phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
  endfunction

endpackage

// File: rtl/bcs_rdy_sync.sv
`timescale 1ns/1ps
module bcs_rdy_sync #(
  parameter int STAGES = 2,
  parameter bit HALF   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic front;
  logic [STAGES-1:0] chain;

  generate
    if (HALF) begin : g_half
      logic neg_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= d;
      end
      assign front = neg_q;
    end else begin : g_direct
      assign front = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], front};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bcs_phase_fsm.sv
`timescale 1ns/1ps
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       hold,
  input  logic       rdy,
  output phase_e     phase,
  output logic [2:0] kind,
  output logic       req_ready,
  output logic       accept,
  output logic       ready_taken
);
  phase_e nxt;
  logic   go;

  assign req_ready   = (phase == PH_IDLE) && !hold;
  assign accept      = req_ready && req_valid && (req_kind != K_IDLE);
  assign go          = !kind_waits(kind) || rdy;
  assign ready_taken = ((phase == PH_T3) || (phase == PH_TW)) && go;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: begin
        if (hold)        nxt = PH_HOLD;
        else if (accept) nxt = PH_T1;
      end
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = go ? PH_T4 : PH_TW;
      PH_TW:   nxt = go ? PH_T4 : PH_TW;
      PH_T4:   nxt = hold ? PH_HOLD : PH_IDLE;
      PH_HOLD: nxt = hold ? PH_HOLD : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      kind  <= K_IDLE;
    end else begin
      phase <= nxt;
      if (accept) kind <= req_kind;
    end
  end
endmodule

// File: rtl/bcs_pin_drive.sv
`timescale 1ns/1ps
module bcs_pin_drive
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int AO_W  = ADDR_W - 4 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [2:0]        kind,
  input  logic              accept,
  input  logic [2:0]        req_kind,
  input  logic              ready_taken,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              dma_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [AO_W-1:0]   ao_hi,
  output logic              bus_oe,
  output logic [2:0]        status,
  output logic              s6,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wb_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              upper_zero,
  output logic              hlda,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic in_cyc, in_strobe, in_data, is_wr, is_rd;

  always_comb begin
    in_cyc    = phase_in_cycle(phase);
    in_strobe = phase_strobe(phase);
    in_data   = phase_data(phase);
    is_wr     = kind_writes(kind);
    is_rd     = kind_reads(kind);

    status     = (in_cyc && phase != PH_T4) ? kind : K_IDLE;
    ale        = (phase == PH_T1);
    rd_n       = !(in_strobe && is_rd);
    wr_n       = !(in_strobe && is_wr);
    wb_n       = !(in_cyc && is_wr);
    den_n      = !(in_data && kind != K_HALT);
    ad_oe      = (phase == PH_T1) || (in_data && is_wr);
    ad_out     = (phase == PH_T1) ? addr_q[DATA_W-1:0] : wdata_q;
    ao_hi      = addr_q[ADDR_W-5:DATA_W];
    upper_zero = in_cyc && nibble_has_zero(addr_q[ADDR_W-1:ADDR_W-4]);
    s6         = in_data && dma_q;
    bus_oe     = (phase != PH_HOLD);
    hlda       = (phase == PH_HOLD);
    rd_valid   = (phase == PH_T4) && is_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_r    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (accept) dt_r <= kind_writes(req_kind);
      if (ready_taken && is_rd) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AO_W       = ADDR_W - 4 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_dma,
  output logic              req_ready,
  input  logic              rdy_async,
  input  logic              rdy_sync,
  input  logic              hold,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] addr_out,
  output logic [AO_W-1:0]   ao_hi,
  output logic              bus_oe,
  output logic [2:0]        status,
  output logic              s6,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wb_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              upper_zero,
  output logic              hlda,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [1:0]        rdy_raw, rdy_synced;
  logic              rdy_merged;
  phase_e            phase_w;
  logic [2:0]        kind_w;
  logic              accept_w, ready_taken_w, arm_nm;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              dma_q;

  // index 0: synchronous ready, index 1: asynchronous ready (extra half stage)
  assign rdy_raw = {rdy_async, rdy_sync};

  for (genvar i = 0; i < 2; i++) begin : g_rdy
    bcs_rdy_sync #(.STAGES(SYNC_STAGES), .HALF(i == 1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rdy_raw[i]), .q(rdy_synced[i])
    );
  end

  assign rdy_merged = |rdy_synced;

  bcs_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .hold(hold), .rdy(rdy_merged), .phase(phase_w), .kind(kind_w),
    .req_ready(req_ready), .accept(accept_w), .ready_taken(ready_taken_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      dma_q   <= 1'b0;
    end else if (accept_w) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      dma_q   <= req_dma;
    end
  end

  // falling-edge stage: the plain address leads the multiplexed bus by half a clock
  assign arm_nm = req_ready && req_valid && (req_kind != K_IDLE);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      addr_out <= '0;
    else if (arm_nm) addr_out <= req_addr;
  end

  bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase_w), .kind(kind_w),
    .accept(accept_w), .req_kind(req_kind), .ready_taken(ready_taken_w),
    .addr_q(addr_q), .wdata_q(wdata_q), .dma_q(dma_q), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ao_hi(ao_hi), .bus_oe(bus_oe),
    .status(status), .s6(s6), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .wb_n(wb_n), .den_n(den_n), .dt_r(dt_r), .upper_zero(upper_zero),
    .hlda(hlda), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
`timescale 1ns/1ps
module bus_cycle_seq_chk
  import bcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input phase_e     phase,
  input logic       rdy_merged,
  input logic       hold,
  input logic       hlda,
  input logic       bus_oe,
  input logic       ad_oe,
  input logic       ale,
  input logic [2:0] status,
  input logic       rd_n,
  input logic       wr_n,
  input logic       den_n,
  input logic       dt_r,
  input logic       upper_zero
);
  AST_STATUS_ON_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> status != 3'b111); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3
  AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TW) |-> !$past(rdy_merged)); // R4
  AST_HALT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b011) |-> (rd_n && wr_n)); // R5
  AST_UZ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2 || phase == PH_T3 || phase == PH_TW || phase == PH_T4) |-> $stable(upper_zero)); // R6
  AST_HLDA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(phase == PH_IDLE || phase == PH_T4)); // R7
  AST_HLDA_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ad_oe)); // R7
  AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> !$past(hold)); // R7
  AST_DEN_ON_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dt_r) |-> den_n); // R8
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_w), .rdy_merged(rdy_merged),
  .hold(hold), .hlda(hlda), .bus_oe(bus_oe), .ad_oe(ad_oe), .ale(ale),
  .status(status), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
  .upper_zero(upper_zero)
);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'b111;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_dma = 1'b0;
  logic        rdy_async = 1'b0;
  logic        rdy_sync = 1'b0;
  logic        hold = 1'b0;
  logic [7:0]  ad_in = '0;
  logic        req_ready, ad_oe, bus_oe, s6, ale, rd_n, wr_n, wb_n, den_n, dt_r;
  logic        upper_zero, hlda, rd_valid;
  logic [7:0]  ad_out, ao_hi, rd_data;
  logic [19:0] addr_out;
  logic [2:0]  status;

  int errs = 0;
  int total = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_dma(req_dma),
    .req_ready(req_ready), .rdy_async(rdy_async), .rdy_sync(rdy_sync),
    .hold(hold), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_out(addr_out), .ao_hi(ao_hi), .bus_oe(bus_oe), .status(status),
    .s6(s6), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .wb_n(wb_n),
    .den_n(den_n), .dt_r(dt_r), .upper_zero(upper_zero), .hlda(hlda),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // fields: kind[44:42] addr[41:22] wdata[21:14] rdata[13:6] async[5] lag[4:1] dma[0]
  localparam int NV = 10;
  localparam logic [44:0] VT [NV] = '{
    {3'd5, 20'h12345, 8'h00, 8'hA5, 1'b0, 4'd0, 1'b0},
    {3'd6, 20'hF8001, 8'h3C, 8'h00, 1'b0, 4'd2, 1'b0},
    {3'd1, 20'h00F0E, 8'h00, 8'h5A, 1'b1, 4'd1, 1'b0},
    {3'd2, 20'h0FF00, 8'hC3, 8'h00, 1'b1, 4'd3, 1'b1},
    {3'd4, 20'hFFFF0, 8'h00, 8'h90, 1'b0, 4'd0, 1'b0},
    {3'd0, 20'h00000, 8'h00, 8'h08, 1'b1, 4'd0, 1'b0},
    {3'd3, 20'h3A5A5, 8'h00, 8'h00, 1'b0, 4'd4, 1'b0},
    {3'd5, 20'hE0102, 8'h00, 8'h7E, 1'b1, 4'd5, 1'b1},
    {3'd6, 20'h54321, 8'h81, 8'h00, 1'b0, 4'd7, 1'b0},
    {3'd4, 20'h7FFFE, 8'h00, 8'h11, 1'b1, 4'd2, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cyc(input logic [44:0] v, input int hold_at);
    logic [2:0] k; logic [19:0] a; logic [7:0] wd, rv; bit asy, dm, isw, isr, hl;
    int lag, w, n_ale, n_rd, n_wr, n_wb, n_den, n_s6, n_uz, n_st;
    k = v[44:42]; a = v[41:22]; wd = v[21:14]; rv = v[13:6];
    asy = v[5]; lag = int'(v[4:1]); dm = v[0];
    isw = (k == 3'd2) || (k == 3'd6);
    isr = (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
    hl  = (k == 3'd3);
    w   = hl ? 0 : lag;
    n_ale = 0; n_rd = 0; n_wr = 0; n_wb = 0; n_den = 0; n_s6 = 0; n_uz = 0; n_st = 0;
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_dma = dm;
    ad_in = rv; rdy_sync = 1'b0; rdy_async = 1'b0;
    @(negedge clk); #2;
    chk(addr_out == a && !ad_oe && !ale, "R10 plain address leads bus", int'(addr_out), int'(a));
    @(posedge clk); #2;
    req_valid = 1'b0;
    for (int c = 0; c < w + 6; c++) begin
      if (c == lag) begin
        if (asy) rdy_async = 1'b1; else rdy_sync = 1'b1;
      end
      if (c == hold_at) hold = 1'b1;
      @(negedge clk); #2;
      n_ale += int'(ale);   n_rd += int'(!rd_n); n_wr += int'(!wr_n);
      n_wb  += int'(!wb_n); n_den += int'(!den_n); n_s6 += int'(s6);
      n_uz  += int'(upper_zero); n_st += int'(status == k);
      if (c == 0) begin
        chk(ad_oe && ad_out == a[7:0], "R2 address on AD in T1", int'(ad_out), int'(a[7:0]));
        chk(ao_hi == a[15:8], "R2 upper address byte", int'(ao_hi), int'(a[15:8]));
      end
      if (c == 1) chk(dt_r == isw, "R8 direction", int'(dt_r), int'(isw));
      if (c == 2 && isw) chk(ad_oe && ad_out == wd, "R2 write data on AD", int'(ad_out), int'(wd));
      if (c == 3 + w) begin
        chk(rd_valid == isr && status == 3'b111, "R11 R1 T4 valid and passive", int'(rd_valid), int'(isr));
        if (isr) chk(rd_data == rv, "R11 read data", int'(rd_data), int'(rv));
      end
      if (hold_at >= 0 && c == 3 + w) chk(!hlda, "R7 no grant before T4 ends", int'(hlda), 0);
      if (hold_at >= 0 && c == 4 + w) chk(hlda && !bus_oe, "R7 grant after T4", int'(hlda), 1);
      @(posedge clk); #2;
    end
    chk(n_ale == 1, "R2 ale cycles", n_ale, 1);
    chk(n_st == 3 + w, "R1 status cycles", n_st, 3 + w);
    chk(n_rd == (isr ? 2 + w : 0), "R3 R4 read strobe width", n_rd, isr ? 2 + w : 0);
    chk(n_wr == (isw ? 2 + w : 0), "R3 R4 write strobe width", n_wr, isw ? 2 + w : 0);
    chk(n_wb == (isw ? 4 + w : 0), "R3 byte write width", n_wb, isw ? 4 + w : 0);
    chk(n_den == (hl ? 0 : 3 + w), "R8 R5 enable width", n_den, hl ? 0 : 3 + w);
    chk(n_s6 == (dm ? 3 + w : 0), "R9 dma indicator", n_s6, dm ? 3 + w : 0);
    chk(n_uz == ((a[19:16] != 4'hF) ? 4 + w : 0), "R6 upper zero", n_uz, (a[19:16] != 4'hF) ? 4 + w : 0);
    if (hold_at >= 0) begin
      hold = 1'b0;
      @(posedge clk); #2;
      @(negedge clk); #2;
      chk(!hlda && bus_oe, "R7 release after hold low", int'(hlda), 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errs++; total++;
      $display("FAIL WATCHDOG: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(req_ready && bus_oe && !hlda && !ale, "R12 reset idle", int'(req_ready), 1);
    chk(rd_n && wr_n && wb_n && den_n && status == 3'b111, "R12 reset strobes", int'(status), 7);

    for (int i = 0; i < NV; i++) run_cyc(VT[i], -1);

    // passive kind never starts a cycle
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = 3'b111;
    seen = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #2; seen += int'(ale);
      @(posedge clk); #2;
    end
    req_valid = 1'b0;
    chk(seen == 0, "R1 passive kind refused", seen, 0);

    // hold from idle
    @(posedge clk); #2;
    hold = 1'b1;
    @(negedge clk); #2;
    chk(!req_ready, "R7 not ready while hold", int'(req_ready), 0);
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = 3'd5;
    @(negedge clk); #2;
    chk(hlda && !bus_oe && !ad_oe, "R7 idle grant floats bus", int'(bus_oe), 0);
    seen = 0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #2;
      @(negedge clk); #2; seen += int'(ale);
    end
    chk(seen == 0, "R7 no cycle during grant", seen, 0);
    @(posedge clk); #2;
    req_valid = 1'b0; hold = 1'b0;
    @(negedge clk); #2;
    chk(hlda, "R7 grant held until hold seen low", int'(hlda), 1);
    @(posedge clk); #2;
    @(negedge clk); #2;
    chk(!hlda && req_ready, "R7 grant dropped", int'(hlda), 0);

    // hold raised in T2 of a read
    run_cyc({3'd5, 20'h2468A, 8'h00, 8'hE7, 1'b0, 4'd1, 1'b0}, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule